// File: doc/BRIEF.md
# Bidirectional Oscillator Disturbance Alarm

This block watches a free-running ring oscillator for brief changes in its frequency, such as those a laser spot or an electromagnetic pulse causes near the protected logic. Three taps come from the same oscillator loop in a fixed phase order. The middle tap passes through a selectable chain of delay cells and then clocks two capture flops: one samples the leading tap, the other samples the complement of the lagging tap. In steady oscillation both captured bits are 1, so their AND, the raw health bit, stays 1. If the oscillator speeds up, the lagging tap reaches its rising edge before the delayed sampling edge. If it slows down, the leading tap has already fallen. In both cases a captured bit becomes 0 and the raw health bit drops. The number of delay cells on the sampling edge sets how large an excursion is needed to trip the detector.

A single injection usually disturbs several oscillator periods. The block therefore keeps only the first drop, in a sticky trip flop in the oscillator domain. That trip is carried through a two-flop synchronizer into the system clock domain. There it sets a sticky alarm output and advances a saturating event counter. Clearing the alarm also re-arms the trip flop. For a programmable number of system cycles after the oscillator is enabled, or after the delay setting changes while it is enabled, the trip flop is held cleared. This keeps start-up transients from being reported.

Top module: `osc_upset_monitor`

## Requirements
- R1: With the oscillator enabled and past the start-up mask, a steady tap pattern leaves `alarm` at 0 and `evt_cnt` unchanged. In that pattern, at each rising edge of the middle tap, `tap_lead` is 1 and `tap_lag` is 0.
- R2: A speed-up excursion raises `alarm` within 5 system cycles and increments `evt_cnt`. Here a speed-up is a sampling edge at which `tap_lag` is already 1, because the lagging tap is captured inverted. `alarm` then stays 1 with no further disturbance.
- R3: A slow-down excursion raises `alarm` within 5 system cycles and increments `evt_cnt`. Here a slow-down is a sampling edge at which `tap_lead` is already 0.
- R4: Several failing samples before a clear count as a single event: `evt_cnt` advances by exactly 1.
- R5: A one-cycle `clr` pulse drops `alarm` on the next system cycle and leaves `evt_cnt` unchanged. A disturbance that arrives 6 or more cycles later is latched and counted again.
- R6: For MASK_CYC (default 16) system cycles after `osc_en` rises, disturbances are ignored. A disturbance after the mask is still detected.
- R7: A change of `dly_sel` while enabled restarts the start-up mask. The mask takes effect from the second system clock edge after the change.
- R8: While `osc_en` is 0, disturbances on the taps raise no alarm and no count.
- R9: `evt_cnt` saturates at 255 and stays there on further events.
- R10: After reset, `alarm` is 0 and `evt_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, system domain |
| clr | input | 1 | One-cycle pulse: clears the alarm and re-arms the trip flop |
| osc_en | input | 1 | Oscillator enable; low holds detection off |
| dly_sel | input | 4 | Number of delay cells on the sampling edge |
| tap_lead | input | 1 | Leading oscillator tap |
| tap_mid | input | 1 | Middle oscillator tap (sampling source) |
| tap_lag | input | 1 | Lagging oscillator tap |
| alarm | output | 1 | Sticky disturbance flag, system domain |
| evt_cnt | output | 8 | Saturating count of latched events |

## Verification
The bench drives the three taps as timed stimulus and injects single cycles that are too fast or too slow. This checks both detection directions. A design that sampled the lagging tap uncomplemented would alarm on steady oscillation or would miss speed-ups. Bursts of several bad periods check that an unlatched design, which would count every pulse, is caught. Disturbances injected just after enable, just after a delay-setting change, and while disabled check the mask: a missing mask reload would report start-up noise. A run of more than 255 events checks that the counter holds at its maximum rather than wrapping to 0.

// File: rtl/osc_mon_pkg.sv
`timescale 1ns/1ps
package osc_mon_pkg;
    // state of the oscillator-domain capture stage
    typedef struct packed {
        logic lead_ok;   // leading tap was high at the sampling edge
        logic lag_ok;    // lagging tap was still low at the sampling edge
        logic trip;      // sticky: a failing sample has been seen
    } samp_st_t;

    localparam samp_st_t SAMP_CLEAR = '{lead_ok: 1'b1, lag_ok: 1'b1, trip: 1'b0};
endpackage

// File: rtl/osc_delay_line.sv
`timescale 1ns/1ps
module osc_delay_line #(
    parameter int STAGES = 16,
    localparam int SEL_W = $clog2(STAGES)
) (
    input  logic             src,
    input  logic [SEL_W-1:0] sel,
    output logic             dly_out
);
    // node[n] has passed through n delay cells
    logic [STAGES:0] node;

    assign node[0] = src;

    for (genvar i = 0; i < STAGES; i++) begin : g_cell
        // one buffer cell; its physical delay sets the detection threshold
        assign node[i+1] = node[i];
    end

    always_comb begin
        dly_out = node[0];
        for (int k = 0; k < STAGES; k++) begin
            if (sel == SEL_W'(k)) dly_out = node[k];
        end
    end
endmodule

// File: rtl/osc_edge_sampler.sv
`timescale 1ns/1ps
module osc_edge_sampler
    import osc_mon_pkg::*;
(
    input  logic sclk,      // delayed middle tap
    input  logic clr_a,     // asynchronous re-arm from the system domain
    input  logic tap_lead,
    input  logic tap_lag,
    output logic trip
);
    samp_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.lead_ok = tap_lead;
        st_d.lag_ok  = ~tap_lag;
        // raw health = AND of the two captured bits; a 0 trips and is held
        st_d.trip    = st_q.trip | ~(st_d.lead_ok & st_d.lag_ok);
    end

    always_ff @(posedge sclk or posedge clr_a) begin
        if (clr_a) st_q <= SAMP_CLEAR;
        else       st_q <= st_d;
    end

    assign trip = st_q.trip;

    // R4: only the first drop is kept until re-armed
    a_r4_trip_sticky: assert property (@(posedge sclk) disable iff (clr_a)
        st_q.trip |=> st_q.trip);
endmodule

// File: rtl/osc_mask_timer.sv
`timescale 1ns/1ps
module osc_mask_timer #(
    parameter int MASK_CYC = 16,
    parameter int SEL_W    = 4,
    localparam int CW      = $clog2(MASK_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr,
    output logic             hold      // re-arm level for the trip flop
);
    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [CW-1:0]    cnt;
        logic             hold;
    } mask_st_t;

    mask_st_t m_d, m_q;
    logic     start;

    always_comb begin
        m_d   = m_q;
        start = en & (~m_q.en | (sel != m_q.sel));
        m_d.en  = en;
        m_d.sel = sel;
        if (start)              m_d.cnt = CW'(MASK_CYC);
        else if (m_q.cnt != '0) m_d.cnt = m_q.cnt - CW'(1);
        m_d.hold = clr | ~en | start | (m_q.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q.en   <= 1'b0;
            m_q.sel  <= '0;
            m_q.cnt  <= '0;
            m_q.hold <= 1'b1;
        end else begin
            m_q <= m_d;
        end
    end

    assign hold = m_q.hold;

    a_r6_enable_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !m_q.en) |=> (hold && m_q.cnt == CW'(MASK_CYC)));
    a_r7_sel_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (en && m_q.en && sel != m_q.sel) |=> hold);
    a_r8_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> hold);
endmodule

// File: rtl/osc_upset_monitor.sv
`timescale 1ns/1ps
module osc_upset_monitor #(
    parameter int STAGES   = 16,
    parameter int MASK_CYC = 16,
    parameter int CNT_W    = 8,
    localparam int SEL_W   = $clog2(STAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             osc_en,
    input  logic [SEL_W-1:0] dly_sel,
    input  logic             tap_lead,
    input  logic             tap_mid,
    input  logic             tap_lag,
    output logic             alarm,
    output logic [CNT_W-1:0] evt_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             s3;
        logic             alarm;
        logic [CNT_W-1:0] cnt;
    } top_st_t;

    logic    sclk, trip, hold, evt;
    top_st_t t_d, t_q;

    osc_delay_line #(.STAGES(STAGES)) u_dly (
        .src     (tap_mid),
        .sel     (dly_sel),
        .dly_out (sclk)
    );

    osc_edge_sampler u_samp (
        .sclk     (sclk),
        .clr_a    (hold),
        .tap_lead (tap_lead),
        .tap_lag  (tap_lag),
        .trip     (trip)
    );

    osc_mask_timer #(.MASK_CYC(MASK_CYC), .SEL_W(SEL_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (osc_en),
        .sel   (dly_sel),
        .clr   (clr),
        .hold  (hold)
    );

    always_comb begin
        t_d    = t_q;
        t_d.s1 = trip;
        t_d.s2 = t_q.s1;
        t_d.s3 = t_q.s2;
        evt    = t_q.s2 & ~t_q.s3;
        if (clr)      t_d.alarm = 1'b0;
        else if (evt) t_d.alarm = 1'b1;
        if (evt && t_q.cnt != CNT_MAX) t_d.cnt = t_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign alarm   = t_q.alarm;
    assign evt_cnt = t_q.cnt;

    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !alarm);
    a_r2_alarm_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm && !evt) |=> !alarm);
    a_r4_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(evt_cnt));
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_cnt == CNT_MAX) |=> (evt_cnt == CNT_MAX));
endmodule

// File: tb/sim_osc_upset_monitor.sv
`timescale 1ns/1ps
module sim_osc_upset_monitor;
    localparam int MASK = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       osc_en = 1'b1;
    logic [3:0] dly_sel = 4'd3;
    logic       tap_lead = 1'b0, tap_mid = 1'b0, tap_lag = 1'b0;
    logic       alarm;
    logic [7:0] evt_cnt;

    int n_run = 0;
    int n_fail = 0;
    int glitch_kind = 0;   // 0 none, 1 speed-up period, 2 slow-down period

    osc_upset_monitor u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .osc_en(osc_en), .dly_sel(dly_sel),
        .tap_lead(tap_lead), .tap_mid(tap_mid), .tap_lag(tap_lag),
        .alarm(alarm), .evt_cnt(evt_cnt)
    );

    always #10 clk = ~clk;   // 50 MHz

    // oscillator model, 8 ns period
    initial begin
        forever begin
            if (glitch_kind == 1) begin
                tap_lead = 1'b1; tap_lag = 1'b1;
                #2 tap_mid = 1'b1;
                #2 tap_lead = 1'b0;
                #2 tap_mid = 1'b0;
                #2 tap_lag = 1'b0;
                glitch_kind = 0;
            end else if (glitch_kind == 2) begin
                tap_lead = 1'b1;
                #1 tap_lead = 1'b0;
                #1 tap_mid = 1'b1;
                #2 tap_lag = 1'b1;
                #2 tap_mid = 1'b0;
                #2 tap_lag = 1'b0;
                glitch_kind = 0;
            end else begin
                tap_lead = 1'b1;
                #2 tap_mid = 1'b1;
                #2 tap_lead = 1'b0; tap_lag = 1'b1;
                #2 tap_mid = 1'b0;
                #2 tap_lag = 1'b0;
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic glitch(input int kind);
        glitch_kind = kind;
        wait (glitch_kind == 0);
        #1;
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic t_reset();
        cyc(2);
        check(alarm == 1'b0, "R10 alarm after reset", alarm, 0);
        check(evt_cnt == 8'd0, "R10 count after reset", evt_cnt, 0);
    endtask

    task automatic t_steady();
        cyc(50);
        check(alarm == 1'b0, "R1 steady alarm", alarm, 0);
        check(evt_cnt == 8'd0, "R1 steady count", evt_cnt, 0);
    endtask

    task automatic t_fast();
        glitch(1);
        cyc(5);
        check(alarm == 1'b1, "R2 speed-up alarm", alarm, 1);
        check(evt_cnt == 8'd1, "R2 speed-up count", evt_cnt, 1);
        cyc(20);
        check(alarm == 1'b1, "R2 alarm sticky", alarm, 1);
    endtask

    task automatic t_clear();
        pulse_clr();
        check(alarm == 1'b0, "R5 alarm after clr", alarm, 0);
        check(evt_cnt == 8'd1, "R5 count kept on clr", evt_cnt, 1);
        cyc(10);
        check(alarm == 1'b0, "R5 alarm stays clear", alarm, 0);
    endtask

    task automatic t_slow();
        glitch(2);
        cyc(5);
        check(alarm == 1'b1, "R3 slow-down alarm", alarm, 1);
        check(evt_cnt == 8'd2, "R3 slow-down count", evt_cnt, 2);
        pulse_clr();
        cyc(6);
        check(alarm == 1'b0, "R5 clear after slow-down", alarm, 0);
    endtask

    task automatic t_burst();
        glitch(1);
        glitch(2);
        glitch(1);
        cyc(3);
        glitch(2);
        cyc(8);
        check(alarm == 1'b1, "R4 burst alarm", alarm, 1);
        check(evt_cnt == 8'd3, "R4 burst counted once", evt_cnt, 3);
        pulse_clr();
        cyc(6);
    endtask

    task automatic t_enable_mask();
        osc_en = 1'b0;
        cyc(5);
        @(negedge clk) osc_en = 1'b1;
        glitch(1);
        glitch(2);
        cyc(MASK + 10);
        check(alarm == 1'b0, "R6 masked after enable", alarm, 0);
        check(evt_cnt == 8'd3, "R6 no count during mask", evt_cnt, 3);
        glitch(1);
        cyc(5);
        check(alarm == 1'b1, "R6 detect after mask", alarm, 1);
        check(evt_cnt == 8'd4, "R6 count after mask", evt_cnt, 4);
        pulse_clr();
        cyc(6);
    endtask

    task automatic t_sel_mask();
        @(negedge clk) dly_sel = 4'd9;
        cyc(2);
        glitch(1);
        cyc(MASK / 2);
        glitch(2);
        cyc(MASK + 5);
        check(alarm == 1'b0, "R7 masked after sel change", alarm, 0);
        check(evt_cnt == 8'd4, "R7 no count during mask", evt_cnt, 4);
        glitch(2);
        cyc(5);
        check(alarm == 1'b1, "R7 detect after mask", alarm, 1);
        check(evt_cnt == 8'd5, "R7 count after mask", evt_cnt, 5);
        pulse_clr();
        cyc(6);
    endtask

    task automatic t_disabled();
        @(negedge clk) osc_en = 1'b0;
        cyc(3);
        glitch(1);
        cyc(4);
        glitch(2);
        cyc(10);
        check(alarm == 1'b0, "R8 disabled alarm", alarm, 0);
        check(evt_cnt == 8'd5, "R8 disabled count", evt_cnt, 5);
        @(negedge clk) osc_en = 1'b1;
        cyc(MASK + 10);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 252; i++) begin
            glitch((i % 2) + 1);
            cyc(5);
            pulse_clr();
            cyc(6);
        end
        check(evt_cnt == 8'd255, "R9 count reaches max", evt_cnt, 255);
        glitch(1);
        cyc(5);
        check(alarm == 1'b1, "R9 alarm at max", alarm, 1);
        check(evt_cnt == 8'd255, "R9 count saturates", evt_cnt, 255);
        pulse_clr();
        cyc(6);
        glitch(2);
        cyc(5);
        check(evt_cnt == 8'd255, "R9 count holds", evt_cnt, 255);
    endtask

    initial begin
        cyc(4);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        cyc(MASK + 10);
        t_steady();
        t_fast();
        t_clear();
        t_slow();
        t_burst();
        t_enable_mask();
        t_sel_mask();
        t_disabled();
        t_saturate();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule